// File: doc/BRIEF.md
# Interrupt Status Latch and Request Controller

This block collects three single-cycle interrupt events (periodic tick, alarm match, update complete) into a status register and produces the enable for an active-low, open-drain interrupt request line. An event always sets its flag, so software can poll for it without interrupts. The request line is pulled low only while at least one flag is set and that flag's enable input is 1.

The status register is read-only and clears when it is read. A read is bounded by a begin strobe and an end strobe. At the begin strobe the block captures a snapshot of the status byte and clears the live flags. The status output then holds that snapshot until the end strobe. Events that arrive while the read is open are kept in a pending register. They are merged into the live flags when the read closes, so no event is lost and the value being read never changes under the reader. There is no write path into the status register.

Top module: `irq_status_ctl`

## Requirements
- R1: Each event pulse sets its flag whatever the state of its enable input. The flag is visible on `status_q` in the cycle after the pulse.
- R2: Outside a read, `irq_oe` is 1 exactly when some flag is set whose enable input is 1. When no such flag is set, `irq_oe` is 0, which releases the line.
- R3: Raising an enable input while its flag is already set makes `irq_oe` 1 in that same cycle, with no clock edge between.
- R4: An accepted `rd_begin` clears every live flag. From the following cycle `irq_oe` is 0 until a new event is posted, and after the read closes the status reads 0.
- R5: From the cycle after an accepted `rd_begin` until the accepted `rd_end` edge, `status_q` holds the value it had in the `rd_begin` cycle.
- R6: Events from the `rd_begin` cycle through the `rd_end` cycle, inclusive, are not lost. Each one appears as a flag in the cycle after the read closes.
- R7: Any combination of the three flags, including all three, is reported together in one status byte.
- R8: Status byte layout: bit 6 is the periodic flag, bit 5 the alarm flag, bit 4 the update flag. Bit 7 is the OR over the three flag-and-enable pairs. Bits 3..0 always read 0.
- R9: An `rd_begin` while a read is already open is ignored. An `rd_end` while no read is open is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_periodic | input | 1 | Periodic event pulse |
| evt_alarm | input | 1 | Alarm event pulse |
| evt_update | input | 1 | Update-complete event pulse |
| en_periodic | input | 1 | Periodic interrupt enable |
| en_alarm | input | 1 | Alarm interrupt enable |
| en_update | input | 1 | Update interrupt enable |
| rd_begin | input | 1 | Status read opens |
| rd_end | input | 1 | Status read closes |
| status_q | output | 8 | Status byte (snapshot while a read is open) |
| irq_oe | output | 1 | 1 = pull interrupt line low |

## Verification
The bench sweeps all 64 pairs of event set and enable set, and checks the status byte, the summary bit and the request before and after each read. It places events in the begin cycle, in the middle of a read and in the end cycle. A design that let events into the snapshot, or that dropped them at either boundary, would show a changing read value or a lost flag. The bench also raises an enable while its flag is already set and expects the request in the same cycle, which catches a registered request path. Finally it sends stray begin and end strobes, which a design without the read-state guard would turn into a fresh snapshot or an early merge.

// File: rtl/irq_status_ctl.sv
module irq_status_ctl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       evt_periodic,
  input  logic       evt_alarm,
  input  logic       evt_update,
  input  logic       en_periodic,
  input  logic       en_alarm,
  input  logic       en_update,
  input  logic       rd_begin,
  input  logic       rd_end,
  output logic [7:0] status_q,
  output logic       irq_oe
);
  logic [2:0] flg, pend, evt, en, qual;
  logic [7:0] snap, live;
  logic       in_read, start, finish;

  assign evt    = {evt_periodic, evt_alarm, evt_update};
  assign en     = {en_periodic, en_alarm, en_update};
  assign qual   = flg & en;
  assign live   = {|qual, flg, 4'b0000};
  assign start  = rd_begin & ~in_read;
  assign finish = rd_end & in_read;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flg     <= '0;
      pend    <= '0;
      snap    <= '0;
      in_read <= 1'b0;
    end else if (start) begin
      snap    <= live;
      flg     <= '0;
      pend    <= evt;
      in_read <= 1'b1;
    end else if (finish) begin
      flg     <= pend | evt;
      pend    <= '0;
      in_read <= 1'b0;
    end else if (in_read) begin
      pend <= pend | evt;
    end else begin
      flg <= flg | evt;
    end
  end

  assign status_q = in_read ? snap : live;
  assign irq_oe   = |qual;
endmodule

module irq_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       evt_periodic,
  input logic       evt_alarm,
  input logic       evt_update,
  input logic       en_periodic,
  input logic       en_alarm,
  input logic       en_update,
  input logic       rd_begin,
  input logic       rd_end,
  input logic [7:0] status_q,
  input logic       irq_oe,
  input logic       in_read
);
  a_r1_flag_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_read && !rd_begin && evt_alarm) |=> status_q[5]);
  a_r2_irq_has_summary: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_read && irq_oe) |-> status_q[7]);
  a_r4_clear_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_read && rd_begin) |=> !irq_oe);
  a_r5_snapshot_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (in_read && !rd_end) |=> $stable(status_q));
  a_r8_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    status_q[3:0] == 4'b0000);
  a_r9_stray_end: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_read && !rd_begin && rd_end && status_q[6]) |=> status_q[6]);
endmodule

bind irq_status_ctl irq_status_chk u_chk (.*);

// File: tb/sim_irq_status_ctl.sv
module sim_irq_status_ctl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] evt = '0, en = '0;
  logic rd_begin = 1'b0, rd_end = 1'b0;
  logic [7:0] status_q;
  logic irq_oe;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  irq_status_ctl u0 (
    .clk(clk), .rst_n(rst_n),
    .evt_periodic(evt[2]), .evt_alarm(evt[1]), .evt_update(evt[0]),
    .en_periodic(en[2]), .en_alarm(en[1]), .en_update(en[0]),
    .rd_begin(rd_begin), .rd_end(rd_end),
    .status_q(status_q), .irq_oe(irq_oe));

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] stat(input logic [2:0] f, input logic [2:0] e);
    return {|(f & e), f, 4'b0000};
  endfunction

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic do_read();
    rd_begin = 1'b1; tick(); rd_begin = 1'b0;
    tick();
    rd_end = 1'b1; tick(); rd_end = 1'b0;
  endtask

  task automatic run_all();
    logic [7:0] s;
    rst_n = 1'b0; tick(); tick(); rst_n = 1'b1; tick();
    chk("R8 reset status", status_q, 8'h00);
    chk("R2 reset irq", {7'b0, irq_oe}, 8'h00);

    for (int e = 0; e < 8; e++) begin
      for (int n = 0; n < 8; n++) begin
        en = n[2:0];
        evt = e[2:0]; tick(); evt = '0;
        s = stat(e[2:0], n[2:0]);
        chk("R1 R7 R8 flags", status_q, s);
        chk("R2 irq", {7'b0, irq_oe}, {7'b0, |(e[2:0] & n[2:0])});
        rd_begin = 1'b1; tick(); rd_begin = 1'b0;
        chk("R5 snapshot", status_q, s);
        chk("R4 irq cleared", {7'b0, irq_oe}, 8'h00);
        tick(); tick();
        chk("R5 snapshot held", status_q, s);
        rd_end = 1'b1; tick(); rd_end = 1'b0;
        chk("R4 cleared after read", status_q, 8'h00);
      end
    end

    for (int b = 0; b < 3; b++) begin
      en = '0;
      evt = 3'(1 << b); tick(); evt = '0;
      chk("R3 disabled no irq", {7'b0, irq_oe}, 8'h00);
      en = 3'(1 << b); #1;
      chk("R3 immediate irq", {7'b0, irq_oe}, 8'h01);
      do_read();
    end

    en = 3'b111;
    for (int e = 1; e < 8; e++) begin
      rd_begin = 1'b1; tick(); rd_begin = 1'b0;
      evt = e[2:0]; tick(); evt = '0;
      chk("R5 snapshot not disturbed", status_q, 8'h00);
      chk("R6 irq held off", {7'b0, irq_oe}, 8'h00);
      rd_end = 1'b1; tick(); rd_end = 1'b0;
      chk("R6 deferred mid-read", status_q, stat(e[2:0], 3'b111));
      do_read();
    end

    evt = 3'b100; rd_begin = 1'b1; tick(); rd_begin = 1'b0; evt = '0;
    chk("R6 begin-cycle event excluded", status_q, 8'h00);
    tick();
    evt = 3'b001; rd_end = 1'b1; tick(); rd_end = 1'b0; evt = '0;
    chk("R6 begin and end cycle events", status_q, stat(3'b101, 3'b111));
    do_read();

    evt = 3'b010; tick(); evt = '0;
    rd_begin = 1'b1; tick(); rd_begin = 1'b0;
    evt = 3'b100; tick(); evt = '0;
    rd_begin = 1'b1; tick(); rd_begin = 1'b0;
    chk("R9 second begin ignored", status_q, stat(3'b010, 3'b111));
    rd_end = 1'b1; tick(); rd_end = 1'b0;
    chk("R9 pending after ignored begin", status_q, stat(3'b100, 3'b111));
    rd_end = 1'b1; tick(); rd_end = 1'b0;
    chk("R9 stray end ignored", status_q, stat(3'b100, 3'b111));
    en = 3'b011; #1;
    chk("R2 R8 disabled flag no summary", status_q, 8'h40);
    chk("R2 disabled flag no irq", {7'b0, irq_oe}, 8'h00);
    do_read();
    chk("R4 final clear", status_q, 8'h00);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule